// File: doc/BRIEF.md
# Bank Lane Steering and Odd-Word Splitter

This block connects a processor-side access port to a 16-bit data bus built from two byte-wide banks. The even bank sits on the lower data lines (D0–D7) and the odd bank on the upper lines (D8–D15). The address bits above bit 0 go to both banks together. Address bit 0 and an active-low high-bank enable decide which bank takes part in a cycle.

For every byte or word request the block works out the bank-enable code. On writes it moves data onto the correct lanes, and on reads it gathers it back from them. Memory and I/O requests are both accepted. I/O addresses are cut to the narrower I/O space.

A word at an odd address cannot be carried in one bus cycle. The block splits it into two cycles:
- The first cycle goes to the odd byte at the requested address. Its upper-lane byte becomes the low byte of the result.
- The second cycle goes to the following even address. Its lower-lane byte becomes the high byte.

The request port is stalled while a transfer is in flight. A single completion pulse marks the end of the whole transfer.

Top module: `bank_lane_splitter`

## Requirements
- R1: After reset `req_ready` is 1, `bus_req` is 0 and `done` is 0.
- R2: A byte request at an even address gives one cycle with `bus_addr[0]`=0 and `bus_bhe_n`=1. A write puts the byte on D0–D7. A read returns `{8'h00, D[7:0]}` on `rdata`.
- R3: A byte request at an odd address gives one cycle with `bus_addr[0]`=1 and `bus_bhe_n`=0. A write puts the byte on D8–D15, with D8 as its least significant bit. A read returns `{8'h00, D[15:8]}`.
- R4: A word request at an even address gives one cycle with `bus_addr[0]`=0 and `bus_bhe_n`=0. Write data goes out unchanged on D0–D15, and read data comes back unchanged.
- R5: A word request at an odd address A gives two cycles, A first and then A+1.
  - The first cycle has `bus_bhe_n`=0. A write drives word bits 7:0 on D8–D15.
  - The second cycle has `bus_bhe_n`=1. A write drives word bits 15:8 on D0–D7.
  - A read returns `{second D[7:0], first D[15:8]}`.
- R6: The second address of a split wraps to zero at the top of the space: the memory space of `ADDR_W` bits, or the I/O space of `IO_ADDR_W` bits.
- R7: For I/O requests (`req_io`=1), `bus_io` is 1 and `bus_addr` bits at and above `IO_ADDR_W` are 0. For memory requests `bus_io` is 0 and all address bits are used.
- R8: `done` pulses for exactly one cycle. The pulse comes in the cycle after the `bus_ack` of the final bus cycle. `rdata` is valid with it. There is no pulse after the first half of a split.
- R9: `req_ready` is 0 from the cycle after a request is accepted until `done`. A request presented while busy is ignored: the bus address does not change and no further cycle starts.
- R10: `bus_req` stays high until `bus_ack`. While it waits, `bus_addr`, `bus_bhe_n` and `bus_wdata` do not change.
- R11: `bus_write` equals the write flag of the accepted request for every bus cycle of that transfer.
- R12: Under the default fill option, a write drives the selected byte on both lanes. Only the enabled lane is meaningful.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*LANE_W | Write data; byte in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 2*LANE_W | Read result, valid with done |
| bus_req | output | 1 | Bus cycle requested |
| bus_ack | input | 1 | Bus cycle completed |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_io | output | 1 | Space of the bus cycle |
| bus_addr | output | ADDR_W | Bus address; bit 0 selects the even bank when 0 |
| bus_bhe_n | output | 1 | Active-low odd-bank enable |
| bus_wdata | output | 2*LANE_W | Lane-steered write data |
| bus_rdata | input | 2*LANE_W | Read data from both lanes |

## Verification
The bench builds the block with an 8-bit memory space and a 6-bit I/O space. With these sizes every address of both spaces can be swept for every size and direction, so the wrap at the top of each space is always reached. I/O sweeps pass addresses with bits above the I/O width set, which exercises the truncation. The number of wait cycles before each acknowledge varies with the address. In the first wait of each transfer a stray request is presented, which tests both the hold of the bus signals and the stall.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } bls_state_e;

   typedef struct packed {
      logic write;
      logic word;
      logic io;
      logic split;
   } bls_kind_t;
endpackage

// File: rtl/bls_bank_sel.sv
module bls_bank_sel (
   input  logic lane_odd,
   input  logic word,
   input  logic second,
   output logic bhe_n
);
   // second half of a split always lands on the even bank only
   always_comb begin
      if (second)    bhe_n = 1'b1;
      else if (word) bhe_n = 1'b0;
      else           bhe_n = ~lane_odd;
   end
endmodule

// File: rtl/bls_wr_pack.sv
module bls_wr_pack #(
   parameter int LANE_W    = 8,
   parameter bit REPLICATE = 1'b1,
   localparam int DW       = 2 * LANE_W
) (
   input  logic [DW-1:0] wdata,
   input  logic          full_word,
   input  logic          second,
   input  logic          hi_lane,
   output logic [DW-1:0] lanes
);
   logic [LANE_W-1:0] sel_byte;
   logic [DW-1:0]     steered;

   assign sel_byte = second ? wdata[DW-1:LANE_W] : wdata[LANE_W-1:0];

   generate
      if (REPLICATE) begin : g_rep
         always_comb steered = {sel_byte, sel_byte};
      end else begin : g_zero
         always_comb steered = hi_lane ? {sel_byte, {LANE_W{1'b0}}}
                                       : {{LANE_W{1'b0}}, sel_byte};
      end
   endgenerate

   assign lanes = full_word ? wdata : steered;
endmodule

// File: rtl/bls_rd_unpack.sv
module bls_rd_unpack #(
   parameter int LANE_W = 8,
   localparam int DW    = 2 * LANE_W
) (
   input  logic [DW-1:0]     bus_rdata,
   input  logic [LANE_W-1:0] held_lo,
   input  logic              word,
   input  logic              split,
   input  logic              lane_odd,
   output logic [DW-1:0]     result
);
   always_comb begin
      if (split)         result = {bus_rdata[LANE_W-1:0], held_lo};
      else if (word)     result = bus_rdata;
      else if (lane_odd) result = {{LANE_W{1'b0}}, bus_rdata[DW-1:LANE_W]};
      else               result = {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
   end
endmodule

// File: rtl/bank_lane_splitter.sv
module bank_lane_splitter #(
   parameter int ADDR_W     = 20,
   parameter int IO_ADDR_W  = 16,
   parameter int LANE_W     = 8,
   parameter bit REPLICATE  = 1'b1,
   localparam int DW        = 2 * LANE_W,
   localparam int HI_W      = ADDR_W - IO_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_word,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              done,
   output logic [DW-1:0]     rdata,
   output logic              bus_req,
   input  logic              bus_ack,
   output logic              bus_write,
   output logic              bus_io,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_bhe_n,
   output logic [DW-1:0]     bus_wdata,
   input  logic [DW-1:0]     bus_rdata
);
   import bls_pkg::*;

   generate
      if (IO_ADDR_W < 2 || IO_ADDR_W >= ADDR_W) begin : g_bad_io
         $error("IO_ADDR_W must be at least 2 and below ADDR_W");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("LANE_W must be positive");
      end
   endgenerate

   bls_state_e        state_q;
   bls_kind_t         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     wdata_q;
   logic [LANE_W-1:0] held_lo_q;
   logic [ADDR_W-1:0] req_addr_m;
   logic [ADDR_W-1:0] next_addr;
   logic [DW-1:0]     rd_result;
   logic              second;
   logic              accept;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign second    = (state_q == ST_SECOND);

   // address confined to the selected space, and its wrapping successor
   assign req_addr_m = req_io ? {{HI_W{1'b0}}, req_addr[IO_ADDR_W-1:0]} : req_addr;
   assign next_addr  = kind_q.io
                       ? {{HI_W{1'b0}}, addr_q[IO_ADDR_W-1:0] + IO_ADDR_W'(1)}
                       : addr_q + ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         held_lo_q <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q.write <= req_write;
                  kind_q.word  <= req_word;
                  kind_q.io    <= req_io;
                  kind_q.split <= req_word & req_addr[0];
                  addr_q       <= req_addr_m;
                  wdata_q      <= req_wdata;
                  state_q      <= ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (bus_ack) begin
                  if (kind_q.split) begin
                     held_lo_q <= bus_rdata[DW-1:LANE_W];
                     addr_q    <= next_addr;
                     state_q   <= ST_SECOND;
                  end else begin
                     rdata   <= rd_result;
                     done    <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_SECOND: begin
               if (bus_ack) begin
                  rdata   <= rd_result;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req   = (state_q != ST_IDLE);
   assign bus_write = kind_q.write;
   assign bus_io    = kind_q.io;
   assign bus_addr  = addr_q;

   bls_bank_sel u_sel (
      .lane_odd (addr_q[0]),
      .word     (kind_q.word),
      .second   (second),
      .bhe_n    (bus_bhe_n)
   );

   bls_wr_pack #(
      .LANE_W    (LANE_W),
      .REPLICATE (REPLICATE)
   ) u_pack (
      .wdata     (wdata_q),
      .full_word (kind_q.word & ~kind_q.split),
      .second    (second),
      .hi_lane   (addr_q[0]),
      .lanes     (bus_wdata)
   );

   bls_rd_unpack #(
      .LANE_W (LANE_W)
   ) u_unpack (
      .bus_rdata (bus_rdata),
      .held_lo   (held_lo_q),
      .word      (kind_q.word),
      .split     (kind_q.split),
      .lane_odd  (addr_q[0]),
      .result    (rd_result)
   );
endmodule

// File: rtl/bank_lane_splitter_chk.sv
module bank_lane_splitter_chk #(
   parameter int ADDR_W    = 20,
   parameter int IO_ADDR_W = 16,
   parameter int LANE_W    = 8,
   localparam int DW       = 2 * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              bus_io,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_bhe_n,
   input logic [DW-1:0]     bus_wdata
);
   p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !req_ready);

   p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                 $stable(bus_bhe_n) && $stable(bus_wdata)));

   p_io_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_io) |-> (bus_addr[ADDR_W-1:IO_ADDR_W] == '0));

   p_odd_enables_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr[0]) |-> !bus_bhe_n);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(bus_ack));

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !bus_req));
endmodule

bind bank_lane_splitter bank_lane_splitter_chk #(
   .ADDR_W    (ADDR_W),
   .IO_ADDR_W (IO_ADDR_W),
   .LANE_W    (LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .bus_io    (bus_io),
   .bus_addr  (bus_addr),
   .bus_bhe_n (bus_bhe_n),
   .bus_wdata (bus_wdata)
);

// File: tb/bank_lane_splitter_tb.sv
module bank_lane_splitter_tb;
   localparam int AW = 8;
   localparam int IW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_io = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, done, bus_req, bus_write, bus_io, bus_bhe_n;
   logic [15:0] rdata, bus_wdata;
   logic [AW-1:0] bus_addr;
   logic        bus_ack = 1'b0;
   logic [15:0] bus_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bank_lane_splitter #(.ADDR_W(AW), .IO_ADDR_W(IW), .LANE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_word(req_word), .req_io(req_io), .req_addr(req_addr),
      .req_wdata(req_wdata), .done(done), .rdata(rdata),
      .bus_req(bus_req), .bus_ack(bus_ack), .bus_write(bus_write),
      .bus_io(bus_io), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_txn(input bit wr, input bit wd, input bit io,
                          input logic [AW-1:0] ad);
      logic [AW-1:0] mask, a, exp_addr;
      logic [15:0]   wv, exp_wd, d1, d2, exp_rd;
      logic          exp_bhe;
      bit            split;
      int            ncyc, waits;
      string         tag;
      mask  = io ? AW'((1 << IW) - 1) : '1;
      a     = ad & mask;
      split = wd && a[0];
      ncyc  = split ? 2 : 1;
      waits = int'(ad) % 3;
      wv    = {ad ^ 8'hC3, ~ad};
      d1    = '0;
      d2    = '0;
      if (split)      tag = "R5";
      else if (wd)    tag = "R4";
      else if (a[0])  tag = "R3";
      else            tag = "R2";

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = wd; req_io = io;
      req_addr = ad; req_wdata = wv;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R9 ready low after accept", 32'(req_ready), 0);

      for (int c = 0; c < ncyc; c++) begin
         exp_addr = (c == 0) ? a : ((a + 1'b1) & mask);
         exp_bhe  = (c == 0) ? (wd ? 1'b0 : ~a[0]) : 1'b1;
         if (wd && !split)  exp_wd = wv;
         else if (c == 0)   exp_wd = {wv[7:0], wv[7:0]};
         else               exp_wd = {wv[15:8], wv[15:8]};

         chk(bus_req == 1'b1, {tag, " bus_req"}, 32'(bus_req), 1);
         chk(bus_addr == exp_addr, (c == 1 && a == mask) ? "R6 wrap addr" :
             (io ? "R7 io addr" : {tag, " addr"}), 32'(bus_addr), 32'(exp_addr));
         chk(bus_bhe_n == exp_bhe, {tag, " bhe_n"}, 32'(bus_bhe_n), 32'(exp_bhe));
         chk(bus_io == io, "R7 bus_io", 32'(bus_io), 32'(io));
         chk(bus_write == wr, "R11 bus_write", 32'(bus_write), 32'(wr));
         if (wr)
            chk(bus_wdata == exp_wd, {tag, " R12 lanes"}, 32'(bus_wdata), 32'(exp_wd));

         for (int w = 0; w < waits; w++) begin
            if (c == 0 && w == 0) begin
               req_valid = 1'b1; req_addr = ~ad; req_word = ~wd;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk(bus_req && bus_addr == exp_addr && bus_bhe_n == exp_bhe,
                "R10 hold while waiting", 32'(bus_addr), 32'(exp_addr));
            chk(done == 1'b0, "R8 no early done", 32'(done), 0);
         end

         bus_rdata = {ad + 8'd17 + 8'(c), ad ^ (8'h96 + 8'(c))};
         if (c == 0) d1 = bus_rdata; else d2 = bus_rdata;
         bus_ack = 1'b1;
         @(negedge clk);
         bus_ack = 1'b0;
         bus_rdata = 16'hDEAD;
         if (c < ncyc - 1)
            chk(done == 1'b0, "R8 no done after first half", 32'(done), 0);
      end

      if (split)      exp_rd = {d2[7:0], d1[15:8]};
      else if (wd)    exp_rd = d1;
      else if (a[0])  exp_rd = {8'h00, d1[15:8]};
      else            exp_rd = {8'h00, d1[7:0]};
      chk(done == 1'b1, "R8 done pulse", 32'(done), 1);
      chk(req_ready == 1'b1, "R9 ready with done", 32'(req_ready), 1);
      if (!wr)
         chk(rdata == exp_rd, {tag, " rdata"}, 32'(rdata), 32'(exp_rd));
      @(negedge clk);
      chk(done == 1'b0, "R8 single pulse", 32'(done), 0);
      chk(bus_req == 1'b0, "R9 stray request ignored", 32'(bus_req), 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
      chk(bus_req == 1'b0, "R1 bus_req in reset", 32'(bus_req), 0);
      chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_req == 1'b0, "R1 idle after reset",
          32'(bus_req), 0);
      for (int io = 0; io < 2; io++)
         for (int wr = 0; wr < 2; wr++)
            for (int wd = 0; wd < 2; wd++)
               for (int ad = 0; ad < (1 << AW); ad++)
                  run_txn(wr[0], wd[0], io[0], AW'(ad));
      summary();
      $finish;
   end
endmodule